// File: doc/BRIEF.md
# Dual-Mode Host Parallel Bus Adapter

This block lets an external microcontroller read and write an internal 8-bit register file over a parallel bus. Two strap inputs set the bus style. One strap picks Intel-style strobes (read, address latch enable, write) or Motorola-style strobes (data strobe, address strobe, read/not-write). The other strap picks separate address and data buses or one shared, multiplexed address/data bus. The three control pins are shared between the two strobe styles. The block decodes them together with chip select. It forms the register address and issues register read and write controls. It also tells the pad ring when to drive read data back onto the bus.

All host pins are sampled on the internal clock and handled entirely in that clock domain. A write becomes a single-cycle commit pulse to the register file. The pulse carries the address and data that were on the bus while the strobe was still active.

An interrupt request is also produced from two status registers and their enable masks. It is modelled as a drive-low enable for an open-drain pad. A test input forces every pad driver to high impedance.

The host bus cannot be stalled, so neither the register write port nor the read port has back-pressure. A commit pulse is always accepted. The register file must return read data combinationally for the address presented.

Top module: `hb_host_adapter`

## Requirements
- R1: With Intel strobes (strap `mode_moto`=0), one `reg_wr_en` pulse of exactly one cycle is issued for each low-to-high transition of `ctl_wr` during which `cs_n` was low. `reg_wr_addr`/`reg_wr_data` carry the address and bus value sampled in the last cycle before that transition.
- R2: With Motorola strobes (`mode_moto`=1), one write pulse is issued when the data strobe `ctl_rd` deasserts while `ctl_wr` (read/not-write) is low and `cs_n` is low. The data strobe is active high when `mode_mux`=0 and active low when `mode_mux`=1.
- R3: While `cs_n` is high, no write pulse is issued and `bus_oe` stays low, whatever the strobes do.
- R4: With `mode_mux`=0, the register address is `{ctl_ale, addr_lo[6:0]}`: the latch-enable pin serves as address bit 7.
- R5: With `mode_mux`=1, the address is taken from `bus_in` on the rising edge of `ctl_ale` and held. `addr_lo` is ignored.
- R6: `bus_oe` is high only while `cs_n` is low, a read strobe is active and `test_hiz` is low. A read strobe is `ctl_rd` low for Intel, or the data strobe active with `ctl_wr` high for Motorola. While `bus_oe` is high, `bus_out` equals `reg_rd_data`. After reset `bus_oe` is low.
- R7: While `test_hiz` is high, `bus_oe` and `irq_pull_low` are both low.
- R8: `irq_pull_low` is high when any status bit and its matching enable bit are both set. It goes low once no enabled status bit remains set.
- R9: A Motorola access with `ctl_wr` high produces no write pulse when its data strobe ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; host pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_moto | input | 1 | Strap: 1 = Motorola strobes, 0 = Intel strobes |
| mode_mux | input | 1 | Strap: 1 = multiplexed address/data bus, 0 = separate buses |
| test_hiz | input | 1 | Forces all pad drivers off when high |
| cs_n | input | 1 | Chip select, active low |
| ctl_rd | input | 1 | Read strobe (Intel, active low) or data strobe (Motorola) |
| ctl_ale | input | 1 | Address latch enable / address strobe, or address bit 7 when not multiplexed |
| ctl_wr | input | 1 | Write strobe (Intel, active low) or read/not-write (Motorola) |
| addr_lo | input | 7 | Address bits 6..0 in non-multiplexed mode |
| bus_in | input | 8 | Value seen on the bidirectional bus |
| bus_out | output | 8 | Value to drive onto the bus |
| bus_oe | output | 1 | Bus driver enable |
| reg_rd_addr | output | 8 | Current register address for reads |
| reg_rd_en | output | 1 | Read access in progress |
| reg_rd_data | input | 8 | Read data returned by the register file |
| reg_wr_en | output | 1 | Single-cycle write commit |
| reg_wr_addr | output | 8 | Address of the committed write |
| reg_wr_data | output | 8 | Data of the committed write |
| stat_flags | input | 16 | Two status registers, register 0 in bits 7..0 |
| stat_enable | input | 16 | Enable mask matching `stat_flags` |
| irq_pull_low | output | 1 | Drive-low enable for the open-drain interrupt pad |

## Verification
The bench runs a write in each of the four bus styles. A decoder that used the wrong data-strobe polarity in one Motorola mode would either miss that write or commit it when the strobe rises. Writes are also driven with `cs_n` high, where a decoder that ignored chip select would commit them. A Motorola read is run to the end of its strobe to catch a design that commits on every data-strobe edge regardless of read/not-write. In multiplexed mode, `addr_lo` is held at a value unrelated to the latched address to catch a design that fails to ignore it. `test_hiz` is raised in the middle of an active read with interrupts pending to catch a driver enable that does not honour it.

// File: rtl/hb_pkg.sv
package hb_pkg;

  // Sampled control pins of the host bus
  typedef struct packed {
    logic cs_n;
    logic rd;    // RD (Intel) or data strobe (Motorola)
    logic ale;   // ALE / AS, or address bit 7 when separate buses
    logic wr;    // WR (Intel) or read/not-write (Motorola)
  } hb_ctl_t;

  localparam hb_ctl_t HB_CTL_IDLE = '{cs_n: 1'b1, rd: 1'b1, ale: 1'b0, wr: 1'b1};

  // Motorola data strobe: active high on separate buses, active low when multiplexed
  function automatic logic ds_active(input logic mux, input logic ds_pin);
    return mux ? ~ds_pin : ds_pin;
  endfunction

endpackage

// File: rtl/hb_pin_sampler.sv
module hb_pin_sampler
  import hb_pkg::*;
#(
  parameter int DW  = 8,
  parameter int LAW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  hb_ctl_t        ctl_pin,
  input  logic [LAW-1:0] lo_pin,
  input  logic [DW-1:0]  bus_pin,
  output hb_ctl_t        ctl_cur,
  output hb_ctl_t        ctl_prev,
  output logic [LAW-1:0] lo_cur,
  output logic [LAW-1:0] lo_prev,
  output logic [DW-1:0]  bus_cur,
  output logic [DW-1:0]  bus_prev
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_cur  <= HB_CTL_IDLE;
      ctl_prev <= HB_CTL_IDLE;
      lo_cur   <= '0;
      lo_prev  <= '0;
      bus_cur  <= '0;
      bus_prev <= '0;
    end else begin
      ctl_cur  <= ctl_pin;
      ctl_prev <= ctl_cur;
      lo_cur   <= lo_pin;
      lo_prev  <= lo_cur;
      bus_cur  <= bus_pin;
      bus_prev <= bus_cur;
    end
  end

endmodule

// File: rtl/hb_strobe_decode.sv
module hb_strobe_decode
  import hb_pkg::*;
(
  input  logic    mode_moto,
  input  logic    mode_mux,
  input  hb_ctl_t ctl_cur,
  input  hb_ctl_t ctl_prev,
  output logic    rd_active,
  output logic    wr_commit
);

  logic ds_now, ds_was, rd_moto, rd_intel, wr_moto, wr_intel;

  always_comb begin
    ds_now   = ds_active(mode_mux, ctl_cur.rd);
    ds_was   = ds_active(mode_mux, ctl_prev.rd);
    rd_intel = ~ctl_cur.rd;
    rd_moto  = ds_now & ctl_cur.wr;
    // trailing edge of the active strobe, chip select seen while it was active
    wr_intel = ~ctl_prev.wr & ctl_cur.wr;
    wr_moto  = ds_was & ~ds_now & ~ctl_prev.wr;
    rd_active = ~ctl_cur.cs_n & (mode_moto ? rd_moto : rd_intel);
    wr_commit = ~ctl_prev.cs_n & (mode_moto ? wr_moto : wr_intel);
  end

endmodule

// File: rtl/hb_addr_select.sv
module hb_addr_select #(
  parameter int AW = 8,
  parameter int DW = 8,
  localparam int LAW = AW - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_mux,
  input  logic           ale_cur,
  input  logic           ale_prev,
  input  logic [LAW-1:0] lo_cur,
  input  logic [LAW-1:0] lo_prev,
  input  logic [DW-1:0]  bus_cur,
  output logic [AW-1:0]  addr_now,
  output logic [AW-1:0]  addr_was
);

  logic [AW-1:0] latched_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      latched_q <= '0;
    else if (mode_mux && ale_cur && !ale_prev)
      latched_q <= bus_cur[AW-1:0];
  end

  always_comb begin
    addr_now = mode_mux ? latched_q : {ale_cur, lo_cur};
    addr_was = mode_mux ? latched_q : {ale_prev, lo_prev};
  end

endmodule

// File: rtl/hb_irq_gen.sv
module hb_irq_gen #(
  parameter int DW    = 8,
  parameter int NSTAT = 2,
  localparam int SW   = DW * NSTAT
) (
  input  logic [SW-1:0] flags,
  input  logic [SW-1:0] enables,
  input  logic          hiz,
  output logic          pull_low
);

  logic [NSTAT-1:0] reg_hit;

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    assign reg_hit[g] = |(flags[g*DW +: DW] & enables[g*DW +: DW]);
  end

  assign pull_low = (|reg_hit) & ~hiz;

endmodule

// File: rtl/hb_host_adapter.sv
module hb_host_adapter
  import hb_pkg::*;
#(
  parameter int DW    = 8,
  parameter int AW    = 8,
  parameter int NSTAT = 2,
  localparam int LAW  = AW - 1,
  localparam int SW   = DW * NSTAT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_moto,
  input  logic           mode_mux,
  input  logic           test_hiz,
  input  logic           cs_n,
  input  logic           ctl_rd,
  input  logic           ctl_ale,
  input  logic           ctl_wr,
  input  logic [LAW-1:0] addr_lo,
  input  logic [DW-1:0]  bus_in,
  output logic [DW-1:0]  bus_out,
  output logic           bus_oe,
  output logic [AW-1:0]  reg_rd_addr,
  output logic           reg_rd_en,
  input  logic [DW-1:0]  reg_rd_data,
  output logic           reg_wr_en,
  output logic [AW-1:0]  reg_wr_addr,
  output logic [DW-1:0]  reg_wr_data,
  input  logic [SW-1:0]  stat_flags,
  input  logic [SW-1:0]  stat_enable,
  output logic           irq_pull_low
);

  hb_ctl_t          ctl_pin, ctl_cur, ctl_prev;
  logic [LAW-1:0]   lo_cur, lo_prev;
  logic [DW-1:0]    bus_cur, bus_prev;
  logic             rd_active, wr_commit;
  logic [AW-1:0]    addr_now, addr_was;

  assign ctl_pin = '{cs_n: cs_n, rd: ctl_rd, ale: ctl_ale, wr: ctl_wr};

  hb_pin_sampler #(.DW(DW), .LAW(LAW)) u_sampler (
    .clk(clk), .rst_n(rst_n),
    .ctl_pin(ctl_pin), .lo_pin(addr_lo), .bus_pin(bus_in),
    .ctl_cur(ctl_cur), .ctl_prev(ctl_prev),
    .lo_cur(lo_cur), .lo_prev(lo_prev),
    .bus_cur(bus_cur), .bus_prev(bus_prev)
  );

  hb_strobe_decode u_decode (
    .mode_moto(mode_moto), .mode_mux(mode_mux),
    .ctl_cur(ctl_cur), .ctl_prev(ctl_prev),
    .rd_active(rd_active), .wr_commit(wr_commit)
  );

  hb_addr_select #(.AW(AW), .DW(DW)) u_addr (
    .clk(clk), .rst_n(rst_n), .mode_mux(mode_mux),
    .ale_cur(ctl_cur.ale), .ale_prev(ctl_prev.ale),
    .lo_cur(lo_cur), .lo_prev(lo_prev), .bus_cur(bus_cur),
    .addr_now(addr_now), .addr_was(addr_was)
  );

  hb_irq_gen #(.DW(DW), .NSTAT(NSTAT)) u_irq (
    .flags(stat_flags), .enables(stat_enable), .hiz(test_hiz),
    .pull_low(irq_pull_low)
  );

  // Write commit: one registered pulse with the values seen while the strobe was active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr_en   <= 1'b0;
      reg_wr_addr <= '0;
      reg_wr_data <= '0;
    end else begin
      reg_wr_en <= wr_commit;
      if (wr_commit) begin
        reg_wr_addr <= addr_was;
        reg_wr_data <= bus_prev;
      end
    end
  end

  assign reg_rd_addr = addr_now;
  assign reg_rd_en   = rd_active;
  assign bus_oe      = rd_active & ~test_hiz;
  assign bus_out     = reg_rd_data;

endmodule

// File: rtl/hb_host_adapter_chk.sv
module hb_host_adapter_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_moto,
  input logic test_hiz,
  input logic cs_n,
  input logic ctl_wr,
  input logic bus_oe,
  input logic reg_wr_en,
  input logic irq_pull_low
);

  assert_one_cycle_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

  assert_moto_rw_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && mode_moto) |-> ($past(ctl_wr, 2) == 1'b0));

  assert_commit_needs_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> ($past(cs_n, 2) == 1'b0));

  assert_drive_needs_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ($past(cs_n) == 1'b0));

  assert_hiz_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    test_hiz |-> (!bus_oe && !irq_pull_low));

endmodule

bind hb_host_adapter hb_host_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .test_hiz(test_hiz),
  .cs_n(cs_n), .ctl_wr(ctl_wr), .bus_oe(bus_oe), .reg_wr_en(reg_wr_en),
  .irq_pull_low(irq_pull_low)
);

// File: tb/hb_host_adapter_bench.sv
module hb_host_adapter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_moto = 1'b0, mode_mux = 1'b0, test_hiz = 1'b0;
  logic        cs_n = 1'b1, ctl_rd = 1'b1, ctl_ale = 1'b0, ctl_wr = 1'b1;
  logic [6:0]  addr_lo = '0;
  logic [7:0]  bus_in = '0;
  logic [7:0]  bus_out, reg_rd_addr, reg_wr_addr, reg_wr_data, reg_rd_data;
  logic        bus_oe, reg_rd_en, reg_wr_en, irq_pull_low;
  logic [15:0] stat_flags = '0, stat_enable = '0;

  int checks = 0, fails = 0, wr_cnt = 0;
  logic [7:0] last_addr = '0, last_data = '0;

  always #10 clk = ~clk;

  // register file model: readback is a fixed function of the address
  assign reg_rd_data = reg_rd_addr ^ 8'h5A;

  hb_host_adapter u_hb_host_adapter (
    .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .mode_mux(mode_mux),
    .test_hiz(test_hiz), .cs_n(cs_n), .ctl_rd(ctl_rd), .ctl_ale(ctl_ale),
    .ctl_wr(ctl_wr), .addr_lo(addr_lo), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .reg_rd_addr(reg_rd_addr), .reg_rd_en(reg_rd_en),
    .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wr_data(reg_wr_data), .stat_flags(stat_flags), .stat_enable(stat_enable),
    .irq_pull_low(irq_pull_low)
  );

  always @(posedge clk) if (rst_n && reg_wr_en) begin
    wr_cnt    <= wr_cnt + 1;
    last_addr <= reg_wr_addr;
    last_data <= reg_wr_data;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic idle(input logic moto, input logic mux);
    mode_moto = moto; mode_mux = mux; cs_n = 1'b1; ctl_ale = 1'b0;
    ctl_wr  = moto ? 1'b1 : 1'b1;
    ctl_rd  = moto ? mux : 1'b1;   // Motorola data strobe idle level
    cyc(3);
  endtask

  task automatic mux_addr(input logic [7:0] a);
    bus_in = a; addr_lo = 7'h7F; cyc(1);
    ctl_ale = 1'b1; cyc(2); ctl_ale = 1'b0; cyc(1);
  endtask

  task automatic t_reset();
    check("R6 reset oe", int'(bus_oe), 0);
    check("R1 reset wr", int'(reg_wr_en), 0);
    check("R8 reset irq", int'(irq_pull_low), 0);
  endtask

  task automatic t_intel_sep_write(input logic [7:0] a, input logic [7:0] d);
    int n0;
    idle(1'b0, 1'b0); n0 = wr_cnt;
    {ctl_ale, addr_lo} = a; bus_in = d; cs_n = 1'b0; cyc(1);
    ctl_wr = 1'b0; cyc(2); ctl_wr = 1'b1; cyc(3); cs_n = 1'b1; cyc(1);
    check("R1 intel one pulse", wr_cnt - n0, 1);
    check("R4 sep addr", int'(last_addr), int'(a));
    check("R1 intel data", int'(last_data), int'(d));
  endtask

  task automatic t_intel_sep_read(input logic [7:0] a);
    idle(1'b0, 1'b0);
    {ctl_ale, addr_lo} = a; cs_n = 1'b0; ctl_rd = 1'b0; cyc(2);
    check("R6 intel oe", int'(bus_oe), 1);
    check("R6 R4 read data", int'(bus_out), int'(a ^ 8'h5A));
    ctl_rd = 1'b1; cyc(2);
    check("R6 oe off", int'(bus_oe), 0);
    cs_n = 1'b1; cyc(1);
  endtask

  task automatic t_no_cs();
    int n0;
    idle(1'b0, 1'b0); n0 = wr_cnt;
    ctl_wr = 1'b0; cyc(2); ctl_wr = 1'b1; cyc(3);
    ctl_rd = 1'b0; cyc(2);
    check("R3 no oe", int'(bus_oe), 0);
    ctl_rd = 1'b1; cyc(1);
    idle(1'b1, 1'b0);
    ctl_wr = 1'b0; ctl_rd = 1'b1; cyc(2); ctl_rd = 1'b0; cyc(3);
    check("R3 no write", wr_cnt - n0, 0);
  endtask

  task automatic t_intel_mux_write(input logic [7:0] a, input logic [7:0] d);
    int n0;
    idle(1'b0, 1'b1); n0 = wr_cnt;
    mux_addr(a);
    bus_in = d; cs_n = 1'b0; cyc(1);
    ctl_wr = 1'b0; cyc(2); ctl_wr = 1'b1; cyc(3); cs_n = 1'b1; cyc(1);
    check("R5 mux addr", int'(last_addr), int'(a));
    check("R1 mux data", int'(last_data), int'(d));
    check("R1 mux count", wr_cnt - n0, 1);
    cs_n = 1'b0; ctl_rd = 1'b0; cyc(2);
    check("R5 latched read", int'(bus_out), int'(a ^ 8'h5A));
    ctl_rd = 1'b1; cs_n = 1'b1; cyc(1);
  endtask

  task automatic t_moto_write(input logic mux, input logic [7:0] a, input logic [7:0] d);
    int n0;
    idle(1'b1, mux); n0 = wr_cnt;
    if (mux) mux_addr(a); else {ctl_ale, addr_lo} = a;
    bus_in = d; ctl_wr = 1'b0; cs_n = 1'b0; cyc(1);
    ctl_rd = ~mux; cyc(2);
    check("R2 no pulse while ds active", wr_cnt - n0, 0);
    ctl_rd = mux; cyc(3);
    check("R2 moto one pulse", wr_cnt - n0, 1);
    check("R2 moto addr", int'(last_addr), int'(a));
    check("R2 moto data", int'(last_data), int'(d));
    cs_n = 1'b1; ctl_wr = 1'b1; cyc(1);
  endtask

  task automatic t_moto_read(input logic [7:0] a);
    int n0;
    idle(1'b1, 1'b0); n0 = wr_cnt;
    {ctl_ale, addr_lo} = a; ctl_wr = 1'b1; cs_n = 1'b0; cyc(1);
    ctl_rd = 1'b1; cyc(2);
    check("R6 moto oe", int'(bus_oe), 1);
    check("R6 moto data", int'(bus_out), int'(a ^ 8'h5A));
    ctl_rd = 1'b0; cyc(3);
    check("R9 read no write", wr_cnt - n0, 0);
    check("R6 moto oe off", int'(bus_oe), 0);
    cs_n = 1'b1; cyc(1);
  endtask

  task automatic t_hiz();
    idle(1'b0, 1'b0);
    stat_flags = 16'h0100; stat_enable = 16'h0100;
    cs_n = 1'b0; ctl_rd = 1'b0; cyc(2);
    check("R7 pre oe", int'(bus_oe), 1);
    test_hiz = 1'b1; #1;
    check("R7 hiz oe", int'(bus_oe), 0);
    check("R7 hiz irq", int'(irq_pull_low), 0);
    cyc(1); test_hiz = 1'b0; #1;
    check("R7 release oe", int'(bus_oe), 1);
    ctl_rd = 1'b1; cs_n = 1'b1; stat_flags = '0; stat_enable = '0; cyc(2);
  endtask

  task automatic t_irq();
    stat_flags = 16'h0004; stat_enable = 16'hFF00; #1;
    check("R8 masked", int'(irq_pull_low), 0);
    stat_enable = 16'h0004; #1;
    check("R8 reg0 hit", int'(irq_pull_low), 1);
    stat_flags = 16'h8000; stat_enable = 16'h8000; #1;
    check("R8 reg1 hit", int'(irq_pull_low), 1);
    stat_flags = 16'h0000; #1;
    check("R8 released", int'(irq_pull_low), 0);
    stat_enable = '0; cyc(1);
  endtask

  initial begin
    cyc(3); rst_n = 1'b1; cyc(2);
    t_reset();
    t_intel_sep_write(8'hA5, 8'h3C);
    t_intel_sep_write(8'h3C, 8'hC7);
    t_intel_sep_read(8'h81);
    t_no_cs();
    t_intel_mux_write(8'hD2, 8'h19);
    t_moto_write(1'b0, 8'h96, 8'hE4);
    t_moto_write(1'b1, 8'h4B, 8'h71);
    t_moto_read(8'hF0);
    t_hiz();
    t_irq();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule